// File: doc/BRIEF.md
# Two-Way Handshake Fork with Broadcast and First-Free Delivery

This block takes datagrams from one source channel and passes them to two destination channels. Every channel uses a level request and a one-cycle acknowledge pulse. A static mode input chooses the delivery policy for each datagram. In broadcast mode both destinations receive the same datagram, and the source is released only when both have taken it. In first-free mode the datagram goes to exactly one destination: the first one that reports itself ready. The source is then released on that single acknowledge.

First-free mode suits a pair of identical functional units placed side by side, so that whichever unit is idle takes the next item. Broadcast mode suits places where two consumers each need every item. The datagram itself is not stored. The destination data output follows the source data, which the source holds steady while its request is outstanding.

Top module: `dual_fork`

## Requirements
- R1: After reset, `src_ack` is low and both bits of `dst_req` are low.
- R2: With `mode_bcast` = 1 (broadcast), a source request seen by the fork while idle raises both `dst_req` bits on the following cycle, whatever `dst_rdy` shows. `dst_data` carries `src_data` to both destinations.
- R3: In broadcast mode `src_ack` stays low until both destinations have acknowledged, in either order and at different times. It goes high in the cycle after the clock edge that samples the last acknowledge.
- R4: Once the fork samples an acknowledge on `dst_ack[i]` while `dst_req[i]` is high, it drops `dst_req[i]` on the next cycle, so no destination takes the same datagram twice.
- R5: With `mode_bcast` = 0 (first-free), exactly one `dst_req` bit is raised: bit i for the ready destination i. Destination 0 wins when both are ready in the same cycle. The choice holds until that destination acknowledges.
- R6: In first-free mode, while neither `dst_rdy` bit is set, no `dst_req` is raised and the source is not acknowledged. The pending request is served as soon as a destination becomes ready.
- R7: In first-free mode `src_ack` goes high in the cycle after the edge that samples the single acknowledge from the chosen destination.
- R8: `src_ack` is a one-cycle pulse. In the following cycle the fork is idle and may accept a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_bcast | input | 1 | 1 = broadcast to both, 0 = first-free single delivery |
| src_req | input | 1 | Source request, held until `src_ack` |
| src_data | input | DW | Source datagram, stable while requested |
| src_ack | output | 1 | One-cycle release pulse to the source |
| dst_req | output | 2 | Per-destination request, bit i for destination i |
| dst_rdy | input | 2 | Per-destination ready, used in first-free mode |
| dst_ack | input | 2 | Per-destination one-cycle acknowledge |
| dst_data | output | DW | Datagram presented to the destinations |

## Verification
The assertions assume three things about the inputs. `mode_bcast` is changed only while the fork is idle. `src_data` is held while the fork is busy with a request. A destination pulses `dst_ack` only while its own `dst_req` is high. The stimulus respects all three. The driver sets the mode and data at a falling edge before raising the request, and keeps them until it sees `src_ack`. The destination models acknowledge only after seeing their request, each after a programmed delay, and never twice for one request.

// File: rtl/fork2_pkg.sv
package fork2_pkg;
  localparam int unsigned NUM_DST = 2;

  typedef enum logic [1:0] {
    FK_IDLE = 2'd0,
    FK_BUSY = 2'd1,
    FK_DONE = 2'd2
  } fk_state_t;
endpackage

// File: rtl/fork2_pick.sv
module fork2_pick
  import fork2_pkg::*;
(
  input  logic [NUM_DST-1:0] rdy,
  output logic [NUM_DST-1:0] grant
);
  // lowest index has priority
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < int'(NUM_DST); i++) begin
      if (rdy[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fork2_slot.sv
module fork2_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_val,
  input  logic ack,
  output logic pend
);
  logic pend_d;
  logic pend_en;

  always_comb begin
    pend_d = pend;
    if (load)          pend_d = load_val;
    else if (ack && pend) pend_d = 1'b0;
  end

  assign pend_en = (pend_d != pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (pend_en) pend <= pend_d;
  end

  // R4 (input rule: acknowledge only while requested)
  ack_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> pend);

  // R4
  drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && pend && !load) |=> !pend);
endmodule

// File: rtl/dual_fork.sv
module dual_fork
  import fork2_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_bcast,
  input  logic               src_req,
  input  logic [DW-1:0]      src_data,
  output logic               src_ack,
  output logic [NUM_DST-1:0] dst_req,
  input  logic [NUM_DST-1:0] dst_rdy,
  input  logic [NUM_DST-1:0] dst_ack,
  output logic [DW-1:0]      dst_data
);
  localparam logic [NUM_DST-1:0] ALL_DST = '1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  fk_state_t          state_q, state_d;
  logic               state_en;
  logic [NUM_DST-1:0] pend;
  logic [NUM_DST-1:0] grant;
  logic [NUM_DST-1:0] load_val;
  logic               load;
  logic               any_rdy;

  fork2_pick u_pick (
    .rdy   (dst_rdy),
    .grant (grant)
  );

  assign any_rdy  = |dst_rdy;
  assign load     = (state_q == FK_IDLE) && src_req && (mode_bcast || any_rdy);
  assign load_val = mode_bcast ? ALL_DST : grant;

  for (genvar g = 0; g < int'(NUM_DST); g++) begin : g_slot
    fork2_slot u_slot (
      .clk      (clk),
      .rst_n    (srst_n),
      .load     (load),
      .load_val (load_val[g]),
      .ack      (dst_ack[g]),
      .pend     (pend[g])
    );
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      FK_IDLE: if (load) state_d = FK_BUSY;
      FK_BUSY: if ((pend & ~dst_ack) == '0) state_d = FK_DONE;
      FK_DONE: state_d = FK_IDLE;
      default: state_d = FK_IDLE;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       state_q <= FK_IDLE;
    else if (state_en) state_q <= state_d;
  end

  assign src_ack  = (state_q == FK_DONE);
  assign dst_req  = (state_q == FK_BUSY) ? pend : '0;
  assign dst_data = src_data;

  // R8
  src_pulse_chk: assert property (@(posedge clk) disable iff (!srst_n)
    src_ack |=> !src_ack);

  // R3
  bcast_release_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (dst_req != '0 && (dst_req & ~dst_ack) != '0) |=> !src_ack);

  // R5
  ff_single_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !mode_bcast |-> $onehot0(dst_req));

  // R6
  ff_wait_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == FK_IDLE && !mode_bcast && dst_rdy == '0) |=> (dst_req == '0));

  // R2 (input rule: mode held while busy)
  mode_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q != FK_IDLE) |-> $stable(mode_bcast));

  // R2 (input rule: data held while busy)
  data_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == FK_BUSY) |-> $stable(src_data));
endmodule

// File: tb/sim_dual_fork.sv
module sim_dual_fork;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_bcast = 1'b1;
  logic          src_req = 1'b0;
  logic [DW-1:0] src_data = '0;
  logic          src_ack;
  logic [1:0]    dst_req;
  logic [1:0]    dst_rdy = 2'b00;
  logic [1:0]    dst_ack = 2'b00;
  logic [DW-1:0] dst_data;

  int total = 0;
  int bad = 0;
  bit run = 0;

  logic [DW+1:0] exp_q[$];

  int            lat[2];
  int            cnt[2];
  bit            sent[2];
  bit            jack[2];
  logic [1:0]    seen = 2'b00;
  logic [1:0]    got = 2'b00;
  logic [DW-1:0] gdat[2];
  int            ng = 0;
  int            last_ack = 0;
  bit            prev_sa = 0;

  always #10 clk = ~clk;

  dual_fork #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_bcast(mode_bcast),
    .src_req(src_req), .src_data(src_data), .src_ack(src_ack),
    .dst_req(dst_req), .dst_rdy(dst_rdy), .dst_ack(dst_ack),
    .dst_data(dst_data)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // destination models and result monitor
  always @(negedge clk) begin
    ng++;
    if (run) begin
      for (int i = 0; i < 2; i++) begin
        if (jack[i]) begin
          chk(dst_req[i] == 1'b0, "R4 request dropped after ack", dst_req[i], 0);
          jack[i] = 0;
        end
        dst_ack[i] = 1'b0;
        if (dst_req[i]) begin
          seen[i] = 1'b1;
          if (!sent[i]) begin
            if (cnt[i] >= lat[i]) begin
              dst_ack[i] = 1'b1;
              sent[i] = 1; jack[i] = 1;
              got[i] = 1'b1;
              gdat[i] = dst_data;
              last_ack = ng;
            end else cnt[i]++;
          end
        end else begin
          cnt[i] = 0;
          sent[i] = 0;
        end
      end
      if (prev_sa) chk(src_ack == 1'b0, "R8 single-cycle src_ack", src_ack, 0);
      if (src_ack) begin
        if (exp_q.size() == 0) chk(0, "R8 unexpected src_ack", 1, 0);
        else begin
          logic [DW+1:0] e;
          e = exp_q.pop_front();
          chk(seen == e[DW+1:DW], "R2/R5 requested destinations", seen, e[DW+1:DW]);
          chk(got == e[DW+1:DW], "R3/R7 acks collected before release", got, e[DW+1:DW]);
          chk(ng - last_ack == 1, "R3/R7 release cycle", ng - last_ack, 1);
          for (int i = 0; i < 2; i++)
            if (e[DW+i]) chk(gdat[i] == e[DW-1:0], "R2 delivered data", gdat[i], e[DW-1:0]);
        end
        seen = 2'b00;
        got = 2'b00;
      end
      prev_sa = src_ack;
    end
  end

  // driver: pushes the expected outcome, then runs one handshake
  task automatic send(input bit bc, input logic [1:0] rdy, input int stall,
                      input int l0, input int l1, input logic [DW-1:0] d);
    logic [1:0] m;
    int w;
    @(negedge clk);
    m = bc ? 2'b11 : (rdy[0] ? 2'b01 : 2'b10);
    mode_bcast = bc;
    lat[0] = l0; lat[1] = l1;
    dst_rdy = (stall > 0) ? 2'b00 : rdy;
    exp_q.push_back({m, d});
    src_data = d;
    src_req = 1'b1;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk(dst_req == 2'b00 && src_ack == 1'b0, "R6 no request while none ready",
          {src_ack, dst_req}, 0);
    end
    if (stall > 0) dst_rdy = rdy;
    w = 0;
    do begin
      @(negedge clk);
      w++;
    end while (!src_ack && w < 200);
    if (!src_ack) chk(0, "R3/R7 source never released", 0, 1);
    src_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(src_ack == 1'b0 && dst_req == 2'b00, "R1 reset state", {src_ack, dst_req}, 0);
    run = 1;
    send(1'b1, 2'b00, 0, 0, 3, 16'hA1A1); // R2 rdy ignored, R3 dest0 first
    send(1'b1, 2'b11, 0, 4, 1, 16'hB2B2); // R3 dest1 first
    send(1'b1, 2'b01, 0, 2, 2, 16'hC3C3); // R3 simultaneous acks
    send(1'b0, 2'b11, 0, 1, 1, 16'hD4D4); // R5 both ready -> dest0
    send(1'b0, 2'b10, 0, 0, 0, 16'hE5E5); // R5 only dest1 ready
    send(1'b0, 2'b10, 4, 2, 2, 16'hF6F6); // R6 wait, then dest1
    send(1'b0, 2'b01, 3, 0, 5, 16'h0707); // R6 wait, then dest0
    send(1'b1, 2'b00, 0, 0, 0, 16'h1818); // R8 back-to-back, mode switch
    send(1'b1, 2'b00, 0, 1, 0, 16'h2929);
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all datagrams released", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule